// File: doc/BRIEF.md
# Per-Load Stride Prefetcher

This block watches the stream of load addresses coming out of a core's load port and learns, separately for every load instruction, whether that instruction walks memory with a fixed step. Each load is identified by its instruction pointer. A small direct-mapped table holds, for each tracked instruction, the address it last touched, the step it last took and a saturating confidence count. When an instruction repeats the same step often enough, the block requests a prefetch of the next address in the pattern, that is the current address plus the step.

The step may run forward or backward. Its size is capped, and a request that would leave the 4 KiB page of the triggering access is never made. Only cacheable writeback loads train the table. A fence in progress or a high count of outstanding load misses silences requests while training goes on. Requests leave through a valid/ready port. A request that finds the port stalled is dropped, but the table still learns from that load.

Top module: `ld_stride_pf`

## Requirements
- R1: Loads are tracked per instruction in a 16-entry direct-mapped table indexed by `ld_ip[3:0]` and tagged with `ld_ip[11:4]`. A load whose entry is empty or carries another tag reallocates the entry with its own address, a stored step of zero and a confidence of zero, and it requests nothing.
- R2: On a tag hit the step is the current address minus the stored address. A step equal to the stored step raises a 2-bit confidence that saturates at 3. Any other step lowers the confidence (saturating at 0) and becomes the new stored step. A request is made only when the updated confidence is 2 or more. A steady stream therefore first requests on its fourth load.
- R3: The requested address is the current load address plus the learned step, for both positive and negative steps.
- R4: A step whose magnitude exceeds 2048 bytes counts as a mismatch and is stored as zero, so such a stream never requests.
- R5: A step of zero never produces a request.
- R6: No request is made whose target lies in a different 4 KiB page (address bits 31:12) than the triggering load.
- R7: A load with `ld_wb` low leaves the table unchanged and makes no request.
- R8: While `fence_busy` is high, or while `miss_cnt` is 6 or more, no request is made, but the table still trains.
- R9: Once `pf_valid` is high it stays high with `pf_addr` unchanged until `pf_ready` is seen high. After a handshake with no new request, `pf_valid` goes low.
- R10: A load arriving while the output is stalled updates the table, and its request is discarded.
- R11: After reset the table is empty and `pf_valid` is low.
- R12: A request caused by a load in one cycle appears on `pf_valid`/`pf_addr` after the next clock edge, provided the output was free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_ip | input | 32 | Instruction pointer of the load |
| ld_addr | input | 32 | Byte address of the load |
| ld_wb | input | 1 | Load is to writeback memory |
| fence_busy | input | 1 | A fence is in progress |
| miss_cnt | input | 4 | Number of load misses outstanding |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer accepts the request |
| pf_addr | output | 32 | Prefetch target address |

## Verification
The bench sweeps steady streams over positive, negative, zero, largest legal and just-too-large steps. A design with an off-by-one size cap or a dropped sign would request for the 2049-byte stream or miss the -2048 one. Streams placed against page edges catch a design that lets a request cross into the next page. An aliasing instruction that evicts a trained one catches a design that keeps old confidence across a tag change. A single odd step after saturation separates a confidence that decrements from one that resets. The fence, miss-count, non-writeback and stalled-output cases follow each blocked load with a normal one, so a design that skipped training during suppression, or that trained on non-writeback loads, shows up as a missing or extra request.

// File: rtl/pf_cfg_pkg.sv
package pf_cfg_pkg;
  localparam int unsigned PF_ADDR_W     = 32;
  localparam int unsigned PF_IDX_W      = 4;
  localparam int unsigned PF_TAG_W      = 8;
  localparam int unsigned PF_PAGE_BITS  = 12;
  localparam int unsigned PF_MAX_STRIDE = 2048;
  localparam int unsigned PF_STRIDE_W   = $clog2(PF_MAX_STRIDE) + 2;
  localparam int unsigned PF_CONF_W     = 2;
  localparam int unsigned PF_ENTRIES    = 1 << PF_IDX_W;

  localparam logic signed [PF_ADDR_W-1:0] PF_STRIDE_LIM = PF_ADDR_W'(PF_MAX_STRIDE);

  typedef struct packed {
    logic                   vld;
    logic [PF_TAG_W-1:0]    tag;
    logic [PF_ADDR_W-1:0]   last;
    logic [PF_STRIDE_W-1:0] step;
    logic [PF_CONF_W-1:0]   conf;
  } pf_ent_t;

  // step magnitude within the legal cap
  function automatic logic step_in_cap(input logic [PF_ADDR_W-1:0] d);
    logic signed [PF_ADDR_W-1:0] s;
    s = signed'(d);
    return (s <= PF_STRIDE_LIM) && (s >= -PF_STRIDE_LIM);
  endfunction

  function automatic logic page_same(input logic [PF_ADDR_W-1:0] a,
                                     input logic [PF_ADDR_W-1:0] b);
    return a[PF_ADDR_W-1:PF_PAGE_BITS] == b[PF_ADDR_W-1:PF_PAGE_BITS];
  endfunction

  function automatic logic [PF_CONF_W-1:0] conf_up(input logic [PF_CONF_W-1:0] c);
    return (&c) ? c : c + PF_CONF_W'(1);
  endfunction

  function automatic logic [PF_CONF_W-1:0] conf_dn(input logic [PF_CONF_W-1:0] c);
    return (c == '0) ? c : c - PF_CONF_W'(1);
  endfunction

  function automatic logic [PF_ADDR_W-1:0] step_ext(input logic [PF_STRIDE_W-1:0] s);
    return {{(PF_ADDR_W-PF_STRIDE_W){s[PF_STRIDE_W-1]}}, s};
  endfunction
endpackage

// File: rtl/pf_hist_table.sv
module pf_hist_table
  import pf_cfg_pkg::*;
#(
  parameter int unsigned ENTRIES = PF_ENTRIES,
  localparam int unsigned IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output pf_ent_t       rd_ent,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  pf_ent_t       wr_ent
);
  pf_ent_t mem [ENTRIES];

  assign rd_ent = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_ent;
    end
  end
endmodule

// File: rtl/pf_stride_train.sv
module pf_stride_train
  import pf_cfg_pkg::*;
#(
  parameter int unsigned CONF_ISSUE = 2
) (
  input  logic                 ld_valid,
  input  logic                 ld_wb,
  input  logic [PF_TAG_W-1:0]  ld_tag,
  input  logic [PF_ADDR_W-1:0] ld_addr,
  input  pf_ent_t              cur,
  output logic                 tbl_hit,
  output logic [PF_CONF_W-1:0] conf_next,
  output logic                 wr_en,
  output pf_ent_t              wr_ent,
  output logic                 cand,
  output logic [PF_ADDR_W-1:0] cand_addr
);
  localparam logic [PF_CONF_W-1:0] CONF_MIN = PF_CONF_W'(CONF_ISSUE);

  logic [PF_ADDR_W-1:0]   delta;
  logic                   in_cap;
  logic [PF_STRIDE_W-1:0] step_now;
  logic                   step_match;

  always_comb begin
    tbl_hit    = cur.vld && (cur.tag == ld_tag);
    delta      = ld_addr - cur.last;
    in_cap     = step_in_cap(delta);
    step_now   = in_cap ? delta[PF_STRIDE_W-1:0] : '0;
    step_match = in_cap && (step_now == cur.step);
    conf_next  = step_match ? conf_up(cur.conf) : conf_dn(cur.conf);
    wr_en      = ld_valid && ld_wb;

    wr_ent.vld  = 1'b1;
    wr_ent.tag  = ld_tag;
    wr_ent.last = ld_addr;
    if (tbl_hit) begin
      wr_ent.step = step_now;
      wr_ent.conf = conf_next;
    end else begin
      wr_ent.step = '0;
      wr_ent.conf = '0;
    end

    cand_addr = ld_addr + step_ext(step_now);
    cand = wr_en && tbl_hit && step_match && (step_now != '0)
           && (conf_next >= CONF_MIN) && page_same(ld_addr, cand_addr);
  end
endmodule

// File: rtl/pf_req_port.sv
module pf_req_port
  import pf_cfg_pkg::*;
#(
  parameter int unsigned MISS_W     = 4,
  parameter int unsigned MISS_LIMIT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cand,
  input  logic [PF_ADDR_W-1:0] cand_addr,
  input  logic                 fence_busy,
  input  logic [MISS_W-1:0]    miss_cnt,
  output logic                 issue_fire,
  output logic                 out_free,
  input  logic                 pf_ready,
  output logic                 pf_valid,
  output logic [PF_ADDR_W-1:0] pf_addr
);
  localparam logic [MISS_W-1:0] LIM = MISS_W'(MISS_LIMIT);

  assign issue_fire = cand && !fence_busy && (miss_cnt < LIM);
  assign out_free   = !pf_valid || pf_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (out_free) begin
      pf_valid <= issue_fire;
      if (issue_fire) pf_addr <= cand_addr;
    end
  end
endmodule

// File: rtl/ld_stride_pf.sv
module ld_stride_pf
  import pf_cfg_pkg::*;
#(
  parameter int unsigned IP_W       = 32,
  parameter int unsigned MISS_W     = 4,
  parameter int unsigned MISS_LIMIT = 6,
  parameter int unsigned CONF_ISSUE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid,
  input  logic [IP_W-1:0]      ld_ip,
  input  logic [PF_ADDR_W-1:0] ld_addr,
  input  logic                 ld_wb,
  input  logic                 fence_busy,
  input  logic [MISS_W-1:0]    miss_cnt,
  output logic                 pf_valid,
  input  logic                 pf_ready,
  output logic [PF_ADDR_W-1:0] pf_addr
);
  logic [PF_IDX_W-1:0]  ld_idx;
  logic [PF_TAG_W-1:0]  ld_tag;
  pf_ent_t              cur_ent;
  pf_ent_t              new_ent;
  logic                 tbl_we;
  logic                 tbl_hit;
  logic [PF_CONF_W-1:0] conf_next;
  logic                 cand;
  logic [PF_ADDR_W-1:0] cand_addr;
  logic                 issue_fire;
  logic                 out_free;

  assign ld_idx = ld_ip[PF_IDX_W-1:0];
  assign ld_tag = ld_ip[PF_IDX_W +: PF_TAG_W];

  pf_hist_table #(.ENTRIES(PF_ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ld_idx), .rd_ent(cur_ent),
    .wr_en(tbl_we), .wr_idx(ld_idx), .wr_ent(new_ent)
  );

  pf_stride_train #(.CONF_ISSUE(CONF_ISSUE)) u_train (
    .ld_valid(ld_valid), .ld_wb(ld_wb), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .cur(cur_ent), .tbl_hit(tbl_hit), .conf_next(conf_next),
    .wr_en(tbl_we), .wr_ent(new_ent), .cand(cand), .cand_addr(cand_addr)
  );

  pf_req_port #(.MISS_W(MISS_W), .MISS_LIMIT(MISS_LIMIT)) u_port (
    .clk(clk), .rst_n(rst_n), .cand(cand), .cand_addr(cand_addr),
    .fence_busy(fence_busy), .miss_cnt(miss_cnt),
    .issue_fire(issue_fire), .out_free(out_free),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/ld_stride_pf_chk.sv
module ld_stride_pf_chk
  import pf_cfg_pkg::*;
#(
  parameter int unsigned MISS_W     = 4,
  parameter int unsigned MISS_LIMIT = 6,
  parameter int unsigned CONF_ISSUE = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ld_valid,
  input logic                 ld_wb,
  input logic                 fence_busy,
  input logic [MISS_W-1:0]    miss_cnt,
  input logic [PF_ADDR_W-1:0] ld_addr,
  input logic                 pf_valid,
  input logic                 pf_ready,
  input logic [PF_ADDR_W-1:0] pf_addr,
  input logic                 issue_fire,
  input logic [PF_ADDR_W-1:0] cand_addr,
  input logic                 tbl_hit,
  input logic [PF_CONF_W-1:0] conf_next
);
  localparam logic [MISS_W-1:0]    LIM  = MISS_W'(MISS_LIMIT);
  localparam logic [PF_CONF_W-1:0] CMIN = PF_CONF_W'(CONF_ISSUE);

  logic                        port_free;
  logic signed [PF_ADDR_W-1:0] gap;
  assign port_free = !pf_valid || pf_ready;
  assign gap       = signed'(cand_addr - ld_addr);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr)); // R9
  AST_SUPPRESS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && port_free && (fence_busy || miss_cnt >= LIM || !ld_wb) |=> !pf_valid); // R8
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> cand_addr[PF_ADDR_W-1:PF_PAGE_BITS] == ld_addr[PF_ADDR_W-1:PF_PAGE_BITS]); // R6
  AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> gap != 0 && gap <= PF_STRIDE_LIM && gap >= -PF_STRIDE_LIM); // R4
  AST_CONF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> tbl_hit && conf_next >= CMIN); // R2
  AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire && port_free |=> pf_valid && pf_addr == $past(cand_addr)); // R12
endmodule

bind ld_stride_pf ld_stride_pf_chk #(
  .MISS_W(MISS_W), .MISS_LIMIT(MISS_LIMIT), .CONF_ISSUE(CONF_ISSUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_wb(ld_wb),
  .fence_busy(fence_busy), .miss_cnt(miss_cnt), .ld_addr(ld_addr),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
  .issue_fire(issue_fire), .cand_addr(cand_addr),
  .tbl_hit(tbl_hit), .conf_next(conf_next)
);

// File: tb/test_ld_stride_pf.sv
`timescale 1ns/1ps
module test_ld_stride_pf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_ip = '0;
  logic [31:0] ld_addr = '0;
  logic        ld_wb = 1'b1;
  logic        fence_busy = 1'b0;
  logic [3:0]  miss_cnt = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ld_stride_pf i_ld_stride_pf (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ip(ld_ip),
    .ld_addr(ld_addr), .ld_wb(ld_wb), .fence_busy(fence_busy),
    .miss_cnt(miss_cnt), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr)
  );

  function automatic logic [31:0] mk_ip(input int tag, input int idx);
    return 32'((tag << 4) | idx);
  endfunction

  task automatic check_out(input string req, input bit ev, input logic [31:0] ea);
    checks++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      errors++;
      $display("FAIL %s: pf_valid=%0b pf_addr=%h expected valid=%0b addr=%h",
               req, pf_valid, pf_addr, ev, ea);
    end
  endtask

  // drive one load at a falling edge, sample output one edge later
  task automatic do_load(input logic [31:0] ip, input longint a, input bit wb,
                         input bit fen, input int mc, input bit ev,
                         input longint ea, input string req);
    ld_valid = 1'b1; ld_ip = ip; ld_addr = 32'(a);
    ld_wb = wb; fence_busy = fen; miss_cnt = 4'(mc);
    @(negedge clk);
    ld_valid = 1'b0; ld_wb = 1'b1; fence_busy = 1'b0; miss_cnt = '0;
    check_out(req, ev, 32'(ea));
  endtask

  // steady stream; expectation from R2..R6
  task automatic stream(input int idx, input longint d, input longint base);
    for (int k = 0; k < 5; k++) begin
      longint a, t;
      bit ev, cap;
      a   = base + k * d;
      t   = a + d;
      cap = (d <= 2048) && (d >= -2048);
      ev  = (k >= 3) && (d != 0) && cap && ((a / 4096) == (t / 4096));
      do_load(mk_ip(5, idx), a, 1'b1, 1'b0, 0, ev, t, "R2/R3/R4/R5/R6 stream");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_out("R11 reset", 1'b0, 32'h0);
    @(negedge clk);

    // sweep of steps, each on its own entry
    stream(0, 8,     64'h40100);
    stream(1, 64,    64'h40200);
    stream(2, -64,   64'h43F00);
    stream(3, 2048,  64'h44000);   // crosses page at k=3, legal at k=4
    stream(4, -2048, 64'h47FF0);
    stream(5, 2049,  64'h48000);   // R4 beyond cap
    stream(6, -2049, 64'h4AFFF);
    stream(7, 0,     64'h4C000);   // R5 zero step
    stream(8, 192,   64'h4DC00);   // R6 reaches page edge
    stream(9, -8,    64'h4E010);   // R6 backward edge

    // R1 aliasing tag evicts trained entry
    stream(10, 16, 64'h50000);
    do_load(mk_ip(9, 10), 64'h70000, 1, 0, 0, 0, 0, "R1 alias alloc");
    do_load(mk_ip(5, 10), 64'h50050, 1, 0, 0, 0, 0, "R1 realloc");
    do_load(mk_ip(5, 10), 64'h50060, 1, 0, 0, 0, 0, "R1 retrain c0");
    do_load(mk_ip(5, 10), 64'h50070, 1, 0, 0, 0, 0, "R1 retrain c1");
    do_load(mk_ip(5, 10), 64'h50080, 1, 0, 0, 1, 64'h50090, "R1 retrain c2");

    // R2 one odd step decrements instead of clearing
    stream(11, 64, 64'h51000);
    do_load(mk_ip(5, 11), 64'h51100 + 128, 1, 0, 0, 0, 0, "R2 mismatch");
    do_load(mk_ip(5, 11), 64'h51100 + 256, 1, 0, 0, 1, 64'h51100 + 384, "R2 recover");

    // R8 suppression keeps training, R7 non-writeback ignored
    stream(12, -96, 64'h52800);
    do_load(mk_ip(5, 12), 64'h52800 - 480, 1, 1, 0, 0, 0, "R8 fence");
    do_load(mk_ip(5, 12), 64'h52800 - 576, 1, 0, 6, 0, 0, "R8 miss limit");
    do_load(mk_ip(5, 12), 64'h52800 - 672, 1, 0, 5, 1, 64'h52800 - 768, "R8 below limit");
    do_load(mk_ip(5, 12), 64'h12345, 0, 0, 0, 0, 0, "R7 non-wb");
    do_load(mk_ip(5, 12), 64'h52800 - 768, 1, 0, 0, 1, 64'h52800 - 864, "R7 table kept");

    // R9/R10 stalled output
    stream(13, 32, 64'h53100);
    do_load(mk_ip(5, 13), 64'h531A0, 1, 0, 0, 1, 64'h531C0, "R12 issue");
    pf_ready = 1'b0;
    do_load(mk_ip(5, 13), 64'h531C0, 1, 0, 0, 1, 64'h531C0, "R10 dropped while stalled");
    @(negedge clk);
    check_out("R9 hold", 1'b1, 32'h531C0);
    pf_ready = 1'b1;
    @(negedge clk);
    check_out("R9 release", 1'b0, 32'h0);
    do_load(mk_ip(5, 13), 64'h531E0, 1, 0, 0, 1, 64'h53200, "R10 table updated");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule